// File: doc/BRIEF.md
# Shared Floating-Point Adder and Multiplier Pipeline

This unit is a streaming arithmetic pipeline. On every clock cycle it can take one pair of 16-bit floating-point operands and a function select, and it returns either their sum or their product. The number format has a sign bit, a 5-bit exponent biased by 15, and a 10-bit fraction with an implied leading one. An exponent field of zero stands for the value zero whatever the fraction bits hold. No encoding is set aside for infinity or NaN, and the all-ones exponent is an ordinary finite exponent.

Both functions run through one staged datapath of five register stages. The first stage either aligns the smaller addend or sums the exponents. The second adds the significands or multiplies them. The third normalizes. The fourth rounds to nearest, with ties going to even. The fifth renormalizes when rounding carries out of the significand, then saturates or flushes the exponent. Each operation carries its own select bit through the stages, so additions and multiplications can be freely interleaved, and results come out in the order the operations were issued.

Top module: `fpam_unit`

## Requirements
- R1: An operand whose exponent field (bits 14:10) is zero is treated as zero, and its fraction bits are ignored. Every zero result is output as 16'h0000 with the overflow flag low.
- R2: With `in_op` = 0 the result is the sum a + b. It is rounded to nearest with ties to even, and the rounding decision accounts for every bit shifted out while the exponents are aligned.
- R3: With `in_op` = 1 the result is the product a × b. Its sign is the XOR of the operand signs, and its exponent is the sum of the biased exponents less 15. It is rounded to nearest with ties to even.
- R4: The function select travels with each operation, so adds and multiplies may be issued in any interleaving on consecutive cycles without affecting one another.
- R5: An operation sampled on a rising edge with `in_valid` high appears on the outputs with `out_valid` high directly after the fifth rising edge, counting the sampling edge as the first. Throughput is one result per cycle, results come out in issue order, and a cycle with `in_valid` low gives a cycle with `out_valid` low five edges later.
- R6: When rounding carries the significand to 2.0, the result is renormalized to 1.0 and the exponent goes up by one.
- R7: A result whose biased exponent exceeds 31 after rounding is output as sign, 5'b11111, 10'h3FF, and `out_ovf` is high. `out_ovf` is low in every other case, including every cycle with `out_valid` low.
- R8: A result whose biased exponent falls below 1 after rounding is flushed to 16'h0000.
- R9: Adding two operands of equal magnitude and opposite sign gives exactly 16'h0000.
- R10: While `rst` is high, and on the cycle after it, `out_valid` and `out_ovf` are low. Operations in flight when reset is asserted never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and select are valid this cycle |
| in_op | input | 1 | Function select: 0 add, 1 multiply |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| out_valid | output | 1 | Result valid |
| out_result | output | 16 | Sum or product |
| out_ovf | output | 1 | Result saturated on exponent overflow |

## Verification
The two functions that share a cycle are an addition and a multiplication that sit in neighbouring stages, each reading its own select bit. The bench provokes this by issuing long streams in which the select changes on nearly every cycle, with idle bubbles inserted now and then. Each result is compared in issue order against a reference built on real-number arithmetic with explicit nearest-even rounding. A wrong select pairing, or a stage mixing fields from different operations, therefore shows up as a mismatch in value or in order.

// File: rtl/fpam_pkg.sv
package fpam_pkg;
    parameter int EXP_W = 5;
    parameter int MAN_W = 10;

    localparam int W       = 1 + EXP_W + MAN_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int SIG_W   = MAN_W + 1;
    localparam int ALN_W   = SIG_W + 3;
    localparam int SUM_W   = ALN_W + 1;
    localparam int PRD_W   = 2 * SIG_W;
    localparam int XE_W    = EXP_W + 3;
    localparam int SH_W    = 1 << EXP_W;
    localparam int WIDE_W  = SIG_W + 2 + SH_W;

    typedef struct packed {
        logic                    valid;
        logic                    mul;
        logic                    sign;
        logic                    sub;
        logic                    zero;
        logic signed [XE_W-1:0]  exp;
        logic [ALN_W-1:0]        ma;
        logic [ALN_W-1:0]        mb;
    } prep_t;

    typedef struct packed {
        logic                    valid;
        logic                    mul;
        logic                    sign;
        logic                    zero;
        logic signed [XE_W-1:0]  exp;
        logic [PRD_W-1:0]        raw;
    } core_t;

    typedef struct packed {
        logic                    valid;
        logic                    sign;
        logic                    zero;
        logic signed [XE_W-1:0]  exp;
        logic [SIG_W-1:0]        mant;
        logic                    guard;
        logic                    sticky;
    } norm_t;

    typedef struct packed {
        logic                    valid;
        logic                    sign;
        logic                    zero;
        logic signed [XE_W-1:0]  exp;
        logic [SIG_W:0]          mant;
    } rnd_t;

    typedef struct packed {
        logic                    valid;
        logic                    ovf;
        logic [W-1:0]            res;
    } res_t;

    function automatic logic [XE_W-1:0] lead_zeros(input logic [ALN_W-1:0] v);
        logic [XE_W-1:0] n;
        logic            seen;
        n    = '0;
        seen = 1'b0;
        for (int i = ALN_W - 1; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      n = n + XE_W'(1);
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/fpam_front.sv
module fpam_front
    import fpam_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output core_t        core_o
);
    typedef struct packed {
        prep_t p;
        core_t c;
    } front_t;

    front_t d, q;

    always_comb begin
        logic             sa, sb, za, zb, a_big, s_big;
        logic [EXP_W-1:0] ea, eb, e_big, e_sml, diff;
        logic [SIG_W-1:0] sig_a, sig_b, sig_big, sig_sml;
        logic [WIDE_W-1:0] wide;
        logic [ALN_W-1:0] aligned;

        d = q;
        // stage 1: exponent alignment (add) or exponent sum (multiply)
        sa    = in_a[W-1];
        sb    = in_b[W-1];
        ea    = in_a[W-2 -: EXP_W];
        eb    = in_b[W-2 -: EXP_W];
        za    = (ea == '0);
        zb    = (eb == '0);
        sig_a = za ? '0 : {1'b1, in_a[MAN_W-1:0]};
        sig_b = zb ? '0 : {1'b1, in_b[MAN_W-1:0]};
        a_big   = ({ea, sig_a[MAN_W-1:0]} >= {eb, sig_b[MAN_W-1:0]});
        e_big   = a_big ? ea : eb;
        e_sml   = a_big ? eb : ea;
        sig_big = a_big ? sig_a : sig_b;
        sig_sml = a_big ? sig_b : sig_a;
        s_big   = a_big ? sa : sb;
        diff    = e_big - e_sml;
        wide    = {sig_sml, 2'b00, {SH_W{1'b0}}} >> diff;
        aligned = {wide[WIDE_W-1 -: SIG_W+2], |wide[SH_W-1:0]};

        d.p.valid = in_valid;
        d.p.mul   = in_op;
        if (in_op) begin
            d.p.sign = sa ^ sb;
            d.p.sub  = 1'b0;
            d.p.zero = za | zb;
            d.p.exp  = XE_W'(ea) + XE_W'(eb) - XE_W'(BIAS);
            d.p.ma   = ALN_W'(sig_a);
            d.p.mb   = ALN_W'(sig_b);
        end else begin
            d.p.sign = s_big;
            d.p.sub  = sa ^ sb;
            d.p.zero = za & zb;
            d.p.exp  = XE_W'(e_big);
            d.p.ma   = {sig_big, 3'b000};
            d.p.mb   = aligned;
        end

        // stage 2: significand add/subtract or multiply
        d.c.valid = q.p.valid;
        d.c.mul   = q.p.mul;
        d.c.sign  = q.p.sign;
        d.c.zero  = q.p.zero;
        d.c.exp   = q.p.exp;
        if (q.p.mul)
            d.c.raw = q.p.ma[SIG_W-1:0] * q.p.mb[SIG_W-1:0];
        else if (q.p.sub)
            d.c.raw = PRD_W'({1'b0, q.p.ma} - {1'b0, q.p.mb});
        else
            d.c.raw = PRD_W'({1'b0, q.p.ma} + {1'b0, q.p.mb});
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign core_o = q.c;
endmodule

// File: rtl/fpam_norm.sv
module fpam_norm
    import fpam_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  core_t core_i,
    output norm_t norm_o
);
    norm_t d, q;

    always_comb begin
        logic [SUM_W-1:0] sum;
        logic [XE_W-1:0]  lz;
        logic [ALN_W-1:0] shl;

        d       = q;
        d.valid = core_i.valid;
        d.sign  = core_i.sign;
        d.zero  = core_i.zero;
        d.exp   = core_i.exp;
        sum     = core_i.raw[SUM_W-1:0];
        lz      = lead_zeros(sum[ALN_W-1:0]);
        shl     = sum[ALN_W-1:0] << lz;

        if (core_i.mul) begin
            if (core_i.raw[PRD_W-1]) begin
                d.mant   = core_i.raw[PRD_W-1 -: SIG_W];
                d.guard  = core_i.raw[PRD_W-1-SIG_W];
                d.sticky = |core_i.raw[PRD_W-2-SIG_W:0];
                d.exp    = core_i.exp + XE_W'(1);
            end else begin
                d.mant   = core_i.raw[PRD_W-2 -: SIG_W];
                d.guard  = core_i.raw[PRD_W-2-SIG_W];
                d.sticky = |core_i.raw[PRD_W-3-SIG_W:0];
            end
        end else if (sum[SUM_W-1]) begin
            d.mant   = sum[SUM_W-1 -: SIG_W];
            d.guard  = sum[SUM_W-1-SIG_W];
            d.sticky = |sum[SUM_W-2-SIG_W:0];
            d.exp    = core_i.exp + XE_W'(1);
        end else begin
            d.zero   = core_i.zero | (sum == '0);
            d.mant   = shl[ALN_W-1 -: SIG_W];
            d.guard  = shl[ALN_W-1-SIG_W];
            d.sticky = |shl[ALN_W-2-SIG_W:0];
            d.exp    = core_i.exp - lz;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign norm_o = q;
endmodule

// File: rtl/fpam_round.sv
module fpam_round
    import fpam_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  norm_t norm_i,
    output res_t  res_o
);
    typedef struct packed {
        rnd_t r;
        res_t o;
    } back_t;

    back_t d, q;

    always_comb begin
        logic             inc, carry;
        logic [MAN_W-1:0] m;
        int               e_int;

        d = q;
        // stage 4: round to nearest, ties to even
        inc       = norm_i.guard & (norm_i.sticky | norm_i.mant[0]);
        d.r.valid = norm_i.valid;
        d.r.sign  = norm_i.sign;
        d.r.zero  = norm_i.zero;
        d.r.exp   = norm_i.exp;
        d.r.mant  = {1'b0, norm_i.mant} + (SIG_W+1)'(inc);

        // stage 5: renormalize, then saturate or flush
        carry = q.r.mant[SIG_W];
        m     = carry ? q.r.mant[MAN_W:1] : q.r.mant[MAN_W-1:0];
        e_int = int'($signed(q.r.exp)) + (carry ? 1 : 0);
        d.o.valid = q.r.valid;
        d.o.ovf   = 1'b0;
        d.o.res   = '0;
        if (!q.r.zero) begin
            if (e_int > EXP_MAX) begin
                d.o.res = {q.r.sign, {(W-1){1'b1}}};
                d.o.ovf = q.r.valid;
            end else if (e_int >= 1) begin
                d.o.res = {q.r.sign, EXP_W'(e_int), m};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign res_o = q.o;
endmodule

// File: rtl/fpam_unit.sv
module fpam_unit
    import fpam_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_ovf
);
    core_t core_w;
    norm_t norm_w;
    res_t  res_w;

    fpam_front u_front (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_op    (in_op),
        .in_a     (in_a),
        .in_b     (in_b),
        .core_o   (core_w)
    );

    fpam_norm u_norm (
        .clk    (clk),
        .rst    (rst),
        .core_i (core_w),
        .norm_o (norm_w)
    );

    fpam_round u_round (
        .clk    (clk),
        .rst    (rst),
        .norm_i (norm_w),
        .res_o  (res_w)
    );

    assign out_valid  = res_w.valid;
    assign out_result = res_w.res;
    assign out_ovf    = res_w.ovf;
endmodule

// File: rtl/fpam_checker.sv
module fpam_checker
    import fpam_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_result,
    input logic         out_ovf
);
    logic [4:0] vhist;
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            vhist     <= '0;
            since_rst <= '0;
        end else begin
            vhist <= {vhist[3:0], in_valid};
            if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
        end
    end

    // R5: valid emerges five edges after issue
    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5) |-> (out_valid == vhist[4]));

    // R7: overflow flag only with the saturated magnitude
    assert_ovf_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> (out_valid && out_result[W-2:0] == {(W-1){1'b1}}));

    // R1: zero exponent field only in the canonical zero
    assert_zero_canonical_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_result[W-2 -: EXP_W] == '0) |-> (out_result == '0 && !out_ovf));

    // R10: reset empties the output stage
    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_ovf));
endmodule

bind fpam_unit fpam_checker u_chk (.*);

// File: tb/sim_fpam_unit.sv
module sim_fpam_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_op;
    logic [15:0] in_a, in_b;
    logic        out_valid, out_ovf;
    logic [15:0] out_result;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    fpam_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_result(out_result), .out_ovf(out_ovf)
    );

    // {op, a, b, ovf, result, requirement number}
    localparam int NV = 18;
    localparam logic [53:0] VEC [NV] = '{
        {1'b0, 16'h3C00, 16'h3C00, 1'b0, 16'h4000, 4'd2},  // R2 1+1
        {1'b1, 16'h3E00, 16'h3E00, 1'b0, 16'h4080, 4'd3},  // R3 1.5*1.5
        {1'b0, 16'h4200, 16'hBC00, 1'b0, 16'h4000, 4'd2},  // R2 3-1
        {1'b1, 16'hC000, 16'h4200, 1'b0, 16'hC600, 4'd3},  // R3 -2*3
        {1'b0, 16'h3C00, 16'hBC00, 1'b0, 16'h0000, 4'd9},  // R9 1-1
        {1'b1, 16'h0000, 16'h4200, 1'b0, 16'h0000, 4'd1},  // R1 0*3
        {1'b0, 16'h0123, 16'h4200, 1'b0, 16'h4200, 4'd1},  // R1 junk zero + 3
        {1'b1, 16'h0123, 16'h4000, 1'b0, 16'h0000, 4'd1},  // R1 junk zero * 2
        {1'b0, 16'h3C00, 16'h1000, 1'b0, 16'h3C00, 4'd2},  // R2 tie to even, down
        {1'b0, 16'h3C01, 16'h1000, 1'b0, 16'h3C02, 4'd2},  // R2 tie to even, up
        {1'b0, 16'h3C00, 16'h8400, 1'b0, 16'h3C00, 4'd2},  // R2 sticky subtract
        {1'b0, 16'h3FFF, 16'h1000, 1'b0, 16'h4000, 4'd6},  // R6 round carry
        {1'b1, 16'h7FFF, 16'h4000, 1'b1, 16'h7FFF, 4'd7},  // R7 mul overflow
        {1'b0, 16'h7FFF, 16'h7FFF, 1'b1, 16'h7FFF, 4'd7},  // R7 add overflow
        {1'b0, 16'h7FFF, 16'h5000, 1'b1, 16'h7FFF, 4'd7},  // R7 overflow by rounding
        {1'b1, 16'hFFFF, 16'h4000, 1'b1, 16'hFFFF, 4'd7},  // R7 negative saturation
        {1'b1, 16'h0400, 16'h0400, 1'b0, 16'h0000, 4'd8},  // R8 underflow flush
        {1'b0, 16'hC000, 16'h3C00, 1'b0, 16'hBC00, 4'd4}   // R4 -2+1 after multiplies
    };

    logic        sv   [5];
    logic        sovf [5];
    logic [15:0] sres [5];
    string       stag [5];

    function automatic real pow2(input int e);
        real r = 1.0;
        if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
        else        for (int i = 0; i < -e; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real decode(input logic [15:0] x);
        real v;
        if (x[14:10] == 5'd0) return 0.0;
        v = (1.0 + real'(x[9:0]) / 1024.0) * pow2(int'(x[14:10]) - 15);
        return x[15] ? -v : v;
    endfunction

    // returns {ovf, result}
    function automatic logic [16:0] encode(input real r);
        logic   s;
        real    x, t, rem;
        int     e, b;
        longint q;
        if (r == 0.0) return 17'h0;
        s = (r < 0.0);
        x = s ? -r : r;
        e = 0;
        while (x >= 2.0) begin x = x / 2.0; e++; end
        while (x < 1.0)  begin x = x * 2.0; e--; end
        t   = x * 1024.0;
        q   = longint'($floor(t));
        rem = t - real'(q);
        if (rem > 0.5 || (rem == 0.5 && q[0])) q++;
        if (q == 2048) begin q = 1024; e++; end
        b = e + 15;
        if (b > 31) return {1'b1, s, 15'h7FFF};
        if (b < 1)  return 17'h0;
        return {1'b0, s, 5'(b), q[9:0]};
    endfunction

    function automatic logic [16:0] model(input logic op, input logic [15:0] a, input logic [15:0] b);
        return op ? encode(decode(a) * decode(b)) : encode(decode(a) + decode(b));
    endfunction

    task automatic clear_slots();
        for (int i = 0; i < 5; i++) begin
            sv[i] = 1'b0; sovf[i] = 1'b0; sres[i] = '0; stag[i] = "R5";
        end
    endtask

    // one cycle: check the oldest slot, then issue
    task automatic step(input logic v, input logic op, input logic [15:0] a,
                        input logic [15:0] b, input logic [16:0] expv, input string tag);
        @(negedge clk);
        checks++;
        if (out_valid !== sv[4]) begin
            errors++;
            $display("FAIL R5 out_valid: actual %0b expected %0b", out_valid, sv[4]);
        end
        if (sv[4]) begin
            checks++;
            if ({out_ovf, out_result} !== {sovf[4], sres[4]}) begin
                errors++;
                $display("FAIL %s result: actual ovf=%0b %h expected ovf=%0b %h",
                         stag[4], out_ovf, out_result, sovf[4], sres[4]);
            end
        end else begin
            checks++;
            if (out_ovf !== 1'b0) begin
                errors++;
                $display("FAIL R7 idle ovf: actual %0b expected 0", out_ovf);
            end
        end
        for (int i = 4; i > 0; i--) begin
            sv[i] = sv[i-1]; sovf[i] = sovf[i-1]; sres[i] = sres[i-1]; stag[i] = stag[i-1];
        end
        sv[0] = v; sovf[0] = expv[16]; sres[0] = expv[15:0]; stag[0] = tag;
        in_valid = v; in_op = op; in_a = a; in_b = b;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: actual no finish, expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rng;
        rst = 1'b1; in_valid = 1'b0; in_op = 1'b0; in_a = '0; in_b = '0;
        clear_slots();
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_ovf !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset state: actual v=%0b o=%0b expected 0 0", out_valid, out_ovf);
        end
        rst = 1'b0;

        // table of directed vectors, back to back
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][53], VEC[i][52:37], VEC[i][36:21], VEC[i][20:4],
                 $sformatf("R%0d", VEC[i][3:0]));
        end
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0, '0, '0, "R5");

        // interleaved add/multiply stream with bubbles (R4, R2, R3)
        rng = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            logic        op, v;
            logic [15:0] a, b;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            v  = (i % 7) != 6;
            op = i[0] ^ rng[31] ^ rng[30];
            a  = rng[15:0];
            b  = rng[31:16];
            if (rng[7]) b[14:10] = a[14:10] ^ {3'b000, rng[9:8]};
            if (op) begin a[14] = ~a[13]; b[14] = ~b[13]; end
            step(v, op, a, b, v ? model(op, a, b) : 17'h0, op ? "R3 R4" : "R2 R4");
        end
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, '0, '0, '0, "R5");

        // R10: operations in flight are discarded by reset
        step(1'b1, 1'b0, 16'h3C00, 16'h3C00, 17'h0, "R10");
        step(1'b1, 1'b1, 16'h4000, 16'h4000, 17'h0, "R10");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || out_ovf !== 1'b0) begin
                errors++;
                $display("FAIL R10 during reset: actual v=%0b o=%0b expected 0 0", out_valid, out_ovf);
            end
        end
        clear_slots();
        rst = 1'b0;
        for (int i = 0; i < 7; i++) step(1'b0, 1'b0, '0, '0, '0, "R10");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule